// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block stores one incoming Ethernet frame at a time into a ring of receive buffer descriptors. Software hands it a ring of 8-byte descriptors, each carrying an empty flag, a wrap flag and a buffer base address. When a frame is offered, the engine streams its bytes into as many empty buffers as it needs. The stream is an optional 2-byte alignment pad, then the payload, then the frame's 32-bit CRC. Each consumed descriptor is written back with a length, its empty flag cleared, and on the final one the last flag plus any length error flags.

The payload sits in a frame store. The engine reads it byte by byte through an index and takes the data back in the same cycle. Descriptor fields are also read combinationally at the current ring pointer. After every frame, and on every `kick`, the engine refreshes `rx_active` from the empty flag of the descriptor under the pointer. `restart` loads the pointer from the ring base.

Top module: `rx_bd_ring`

## Requirements
- R1: The stored stream is the payload followed by the four bytes of `frm_crc`, most significant byte first. The CRC bytes count toward the frame's stored length.
- R2: When the stream length (pad + payload + 4) exceeds `trunc_lim`, only the first `trunc_lim` bytes are stored. The last four of those are CRC bytes, and the final descriptor gets both the truncated and length-error flags.
- R3: When the stored length exceeds `max_frm_len` but not `trunc_lim`, the final descriptor gets the length-error flag only.
- R4: Each buffer receives at most `buf_max` bytes, written at consecutive addresses from its base. CRC bytes that straddle a buffer boundary are split across the two buffers.
- R5: If a descriptor without the empty flag is reached mid-frame, storing stops and the rest of the frame is dropped. That descriptor is not written, no frame event fires, and `rx_active` reads 0.
- R6: Every consumed descriptor is written with its byte count. Only the final one has the last flag and pulses `ev_rxf`; each earlier one pulses `ev_rxb`.
- R7: With `shift16` set, two zero bytes are written at the start of the first buffer, ahead of the payload, once per frame.
- R8: After a frame is fully stored, `rx_active` equals the empty flag of the descriptor the pointer has moved to.
- R9: After a descriptor is written, the pointer moves to `ring_base` if that descriptor's wrap flag was set, and otherwise moves on by 8 bytes.
- R10: A frame offered while `rx_active` is 0 is discarded, with no buffer write, descriptor write or event.
- R11: After reset, `rx_active` and `busy` are 0 and `desc_addr` is 0. `restart` loads `ring_base` and clears `rx_active`. `kick` copies the current descriptor's empty flag into `rx_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_base | input | AW | Address of the first descriptor in the ring |
| restart | input | 1 | Load the pointer from `ring_base` and clear `rx_active` (when idle) |
| kick | input | 1 | Sample the current descriptor's empty flag into `rx_active` (when idle) |
| rx_active | output | 1 | An empty descriptor is available |
| busy | output | 1 | A frame is being stored |
| max_frm_len | input | LW | Length above which the length-error flag is set |
| trunc_lim | input | LW | Length at which frames are cut |
| buf_max | input | LW | Maximum bytes per buffer (at least 1) |
| shift16 | input | 1 | Insert the 2-byte zero pad |
| frm_start | input | 1 | Offer a frame (one-cycle pulse) |
| frm_len | input | LW | Payload length of the offered frame |
| frm_crc | input | 32 | CRC to append |
| frm_rd_idx | output | LW | Payload byte index being read |
| frm_rd_data | input | 8 | Payload byte at `frm_rd_idx` |
| desc_addr | output | AW | Address of the current descriptor |
| desc_empty | input | 1 | Empty flag of the descriptor at `desc_addr` |
| desc_wrap | input | 1 | Wrap flag of the descriptor at `desc_addr` |
| desc_buf | input | AW | Buffer base of the descriptor at `desc_addr` |
| desc_wr_en | output | 1 | Write back the descriptor at `desc_addr` and clear its empty flag |
| desc_wr_len | output | LW | Byte count written back |
| desc_wr_last | output | 1 | Last flag written back |
| desc_wr_trunc | output | 1 | Truncated flag written back |
| desc_wr_lenerr | output | 1 | Length-error flag written back |
| buf_wr_en | output | 1 | Buffer byte write strobe |
| buf_wr_addr | output | AW | Buffer byte address |
| buf_wr_data | output | 8 | Buffer byte data |
| ev_rxb | output | 1 | A non-final buffer was completed |
| ev_rxf | output | 1 | A frame was completed |

## Verification
The assertions assume a few things about the inputs. `ring_base` and `buf_max` hold steady while a frame is stored. `buf_max` is at least 1, and `trunc_lim` is at least six, so the CRC always fits. The descriptor fields reflect memory at the current pointer. The stimulus changes these settings only between frames while `busy` is low. It keeps every limit above those minimums, and its model memory answers descriptor reads directly from the same array that the write-back port updates.

// File: rtl/rx_bd_ring.sv
module rx_bd_ring #(
  parameter int AW    = 32,
  parameter int LW    = 16,
  parameter int DSTEP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ring_base,
  input  logic          restart,
  input  logic          kick,
  output logic          rx_active,
  output logic          busy,
  input  logic [LW-1:0] max_frm_len,
  input  logic [LW-1:0] trunc_lim,
  input  logic [LW-1:0] buf_max,
  input  logic          shift16,
  input  logic          frm_start,
  input  logic [LW-1:0] frm_len,
  input  logic [31:0]   frm_crc,
  output logic [LW-1:0] frm_rd_idx,
  input  logic [7:0]    frm_rd_data,
  output logic [AW-1:0] desc_addr,
  input  logic          desc_empty,
  input  logic          desc_wrap,
  input  logic [AW-1:0] desc_buf,
  output logic          desc_wr_en,
  output logic [LW-1:0] desc_wr_len,
  output logic          desc_wr_last,
  output logic          desc_wr_trunc,
  output logic          desc_wr_lenerr,
  output logic          buf_wr_en,
  output logic [AW-1:0] buf_wr_addr,
  output logic [7:0]    buf_wr_data,
  output logic          ev_rxb,
  output logic          ev_rxf
);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_XFER, S_WB, S_NEXT} st_t;
  st_t st;

  logic [AW-1:0] ptr, bbase;
  logic [LW-1:0] total, remain, pos, cnt, chunk;
  logic          active, pad_q, wrap_q, f_tr, f_le;
  logic [31:0]   crc_q;

  logic [LW-1:0] t_raw, t_cut, crc_start;
  logic          t_over;
  logic [1:0]    cj;

  assign t_raw     = frm_len + LW'(4) + (shift16 ? LW'(2) : LW'(0));
  assign t_over    = t_raw > trunc_lim;
  assign t_cut     = t_over ? trunc_lim : t_raw;
  assign crc_start = total - LW'(4);
  assign cj        = 2'(pos - crc_start);

  assign rx_active  = active;
  assign busy       = st != S_IDLE;
  assign desc_addr  = ptr;
  assign frm_rd_idx = pos - (pad_q ? LW'(2) : LW'(0));

  assign buf_wr_en   = st == S_XFER;
  assign buf_wr_addr = bbase + AW'(cnt);
  assign buf_wr_data = (pad_q && pos < LW'(2)) ? 8'h00 :
                       (pos >= crc_start)      ? crc_q[{~cj, 3'b000} +: 8] :
                                                 frm_rd_data;

  assign desc_wr_en     = st == S_WB;
  assign desc_wr_len    = chunk;
  assign desc_wr_last   = remain == chunk;
  assign desc_wr_trunc  = desc_wr_last & f_tr;
  assign desc_wr_lenerr = desc_wr_last & f_le;
  assign ev_rxf         = desc_wr_en & desc_wr_last;
  assign ev_rxb         = desc_wr_en & ~desc_wr_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ptr    <= '0;
      bbase  <= '0;
      active <= 1'b0;
      total  <= '0;
      remain <= '0;
      pos    <= '0;
      cnt    <= '0;
      chunk  <= '0;
      pad_q  <= 1'b0;
      wrap_q <= 1'b0;
      f_tr   <= 1'b0;
      f_le   <= 1'b0;
      crc_q  <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (restart) begin
            ptr    <= ring_base;
            active <= 1'b0;
          end else if (kick) begin
            active <= desc_empty;
          end else if (frm_start && active) begin
            total  <= t_cut;
            remain <= t_cut;
            pos    <= '0;
            pad_q  <= shift16;
            crc_q  <= frm_crc;
            f_tr   <= t_over;
            f_le   <= t_over | (t_cut > max_frm_len);
            st     <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (!desc_empty) begin
            active <= 1'b0;
            st     <= S_IDLE;
          end else begin
            chunk  <= (remain < buf_max) ? remain : buf_max;
            bbase  <= desc_buf;
            wrap_q <= desc_wrap;
            cnt    <= '0;
            st     <= S_XFER;
          end
        end
        S_XFER: begin
          pos <= pos + LW'(1);
          cnt <= cnt + LW'(1);
          if (cnt == chunk - LW'(1)) st <= S_WB;
        end
        S_WB: begin
          remain <= remain - chunk;
          ptr    <= wrap_q ? ring_base : ptr + AW'(DSTEP);
          st     <= desc_wr_last ? S_NEXT : S_FETCH;
        end
        S_NEXT: begin
          active <= desc_empty;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_CHUNK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr_en |-> (desc_wr_len != '0 && desc_wr_len <= buf_max)); // R4

  AST_TRUNC_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_wr_en && desc_wr_trunc) |-> (desc_wr_last && desc_wr_lenerr)); // R2

  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_wr_en && wrap_q) |=> desc_addr == ring_base); // R9

  AST_LOST_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH && !desc_empty) |=> (!rx_active && !busy)); // R5

  AST_DISCARD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !rx_active && frm_start && !restart && !kick) |=> (!busy && !buf_wr_en)); // R10

endmodule

// File: tb/rx_bd_ring_tb.sv
`timescale 1ns/1ps
module rx_bd_ring_tb;
  localparam int AW = 32, LW = 16, ND = 8;
  localparam logic [31:0] BASE = 32'h100;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic [AW-1:0] ring_base = BASE;
  logic restart = 0, kick = 0, shift16 = 0, frm_start = 0;
  logic [LW-1:0] max_frm_len = 16'd1518, trunc_lim = 16'd2048, buf_max = 16'd64, frm_len = 0;
  logic [31:0] frm_crc = 0;
  logic rx_active, busy, desc_wr_en, desc_wr_last, desc_wr_trunc, desc_wr_lenerr;
  logic buf_wr_en, ev_rxb, ev_rxf;
  logic [LW-1:0] frm_rd_idx, desc_wr_len;
  logic [AW-1:0] desc_addr, desc_buf, buf_wr_addr;
  logic [7:0] frm_rd_data, buf_wr_data;
  logic desc_empty, desc_wrap;

  logic [7:0] payload [0:511];
  logic d_empty [0:ND-1];
  logic m_empty [0:ND-1];
  int   m_ptr = 0;
  logic m_active = 0;

  int exp_ba[$], exp_bd[$], exp_da[$], exp_di[$], exp_ev[$];
  int compared = 0, mismatched = 0, cycles = 0;

  function automatic int didx(input logic [AW-1:0] a);
    return int'((a - BASE) >> 3) % ND;
  endfunction

  assign frm_rd_data = payload[frm_rd_idx[8:0]];
  assign desc_empty  = d_empty[didx(desc_addr)];
  assign desc_wrap   = didx(desc_addr) == ND - 1;
  assign desc_buf    = 32'h1000 + 32'(didx(desc_addr)) * 32'h100;

  rx_bd_ring u_dut (.*);

  always @(posedge clk) if (desc_wr_en) d_empty[didx(desc_addr)] <= 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    cycles++;
    if (cycles > 100000) begin
      chk("watchdog", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
    if (buf_wr_en) begin
      if (exp_ba.size() == 0) chk("R10 unexpected buffer write", 1, 0);
      else begin
        chk("R4 buffer address", buf_wr_addr, exp_ba.pop_front());
        chk("R1/R7 buffer byte", buf_wr_data, exp_bd.pop_front());
      end
    end
    if (desc_wr_en) begin
      if (exp_da.size() == 0) chk("R10 unexpected descriptor write", 1, 0);
      else begin
        chk("R9 descriptor address", desc_wr_addr_i(), exp_da.pop_front());
        chk("R6/R2/R3 descriptor length+flags",
            {desc_wr_lenerr, desc_wr_trunc, desc_wr_last, desc_wr_len}, exp_di.pop_front());
      end
    end
    if (ev_rxb || ev_rxf) begin
      if (exp_ev.size() == 0) chk("R6 unexpected event", 1, 0);
      else chk("R6 event kind", {ev_rxf, ev_rxb}, exp_ev.pop_front());
    end
  end

  function automatic int desc_wr_addr_i();
    return int'(desc_addr);
  endfunction

  task automatic predict();
    int total, off, pos, remain, chunk;
    logic tr, le;
    if (!m_active) return;
    off = shift16 ? 2 : 0;
    total = frm_len + 4 + off;
    tr = 0; le = 0;
    if (total > trunc_lim) begin total = trunc_lim; tr = 1; le = 1; end
    if (total > max_frm_len) le = 1;
    pos = 0; remain = total;
    while (remain > 0) begin
      if (!m_empty[m_ptr]) begin m_active = 0; return; end
      chunk = remain < buf_max ? remain : buf_max;
      for (int k = 0; k < chunk; k++) begin
        int b;
        if (pos < off) b = 0;
        else if (pos < total - 4) b = payload[pos - off];
        else b = (frm_crc >> (8 * (3 - (pos - (total - 4))))) & 8'hff;
        exp_ba.push_back(32'h1000 + m_ptr * 32'h100 + k);
        exp_bd.push_back(b);
        pos++;
      end
      remain -= chunk;
      exp_da.push_back(BASE + 8 * m_ptr);
      exp_di.push_back({(remain == 0) & le, (remain == 0) & tr, remain == 0, 16'(chunk)});
      exp_ev.push_back(remain == 0 ? 2 : 1);
      m_empty[m_ptr] = 0;
      m_ptr = (m_ptr == ND - 1) ? 0 : m_ptr + 1;
    end
    m_active = m_empty[m_ptr];
  endtask

  task automatic send(input string req, input int len, input logic [31:0] crc);
    for (int i = 0; i < 512; i++) payload[i] = 8'((i * 7 + len) ^ 8'h5a);
    frm_len = 16'(len); frm_crc = crc;
    predict();
    @(negedge clk); frm_start = 1;
    @(negedge clk); frm_start = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk({req, " queues drained"}, exp_ba.size() + exp_da.size() + exp_ev.size(), 0);
    chk({req, " R8 rx_active"}, rx_active, m_active);
    chk({req, " R9 pointer"}, desc_addr, BASE + 8 * m_ptr);
    for (int i = 0; i < ND; i++) chk({req, " descriptor empty flags"}, d_empty[i], m_empty[i]);
  endtask

  task automatic rearm();
    for (int i = 0; i < ND; i++) begin d_empty[i] = 1; m_empty[i] = 1; end
    @(negedge clk); kick = 1;
    @(negedge clk); kick = 0;
    m_active = m_empty[m_ptr];
    @(negedge clk);
    chk("R11 kick", rx_active, m_active);
  endtask

  initial begin
    for (int i = 0; i < ND; i++) begin d_empty[i] = 1; m_empty[i] = 1; end
    repeat (3) @(negedge clk);
    chk("R11 reset rx_active", rx_active, 0);
    chk("R11 reset busy", busy, 0);
    chk("R11 reset desc_addr", desc_addr, 0);
    rst_n = 1;
    @(negedge clk); restart = 1;
    @(negedge clk); restart = 0;
    @(negedge clk);
    chk("R11 restart pointer", desc_addr, BASE);
    chk("R11 restart clears active", rx_active, 0);
    rearm();
    send("R1 single buffer", 20, 32'hdeadbeef);
    send("R4 three buffers", 150, 32'h01234567);
    send("R4 CRC split", 62, 32'hcafef00d);
    shift16 = 1;
    send("R7 pad", 30, 32'h89abcdef);
    shift16 = 0;
    max_frm_len = 16'd50;
    send("R3 length error, R9 wrap", 60, 32'h13572468);
    chk("R8 ring exhausted", rx_active, 0);
    send("R10 discard while inactive", 40, 32'h11112222);
    max_frm_len = 16'd1518;
    rearm();
    trunc_lim = 16'd100;
    send("R2 truncation", 200, 32'hfeedface);
    trunc_lim = 16'd2048;
    buf_max = 16'd16;
    rearm();
    d_empty[(m_ptr + 1) % ND] = 0; m_empty[(m_ptr + 1) % ND] = 0;
    send("R5 lost frame", 40, 32'h0badf00d);
    chk("R5 inactive after loss", rx_active, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule